// File: doc/BRIEF.md
# Twin-Quad Logic Cell

This block models one programmable function unit of a logic fabric in ordinary RTL. Eight 16-entry look-up tables are split into two groups of four lanes (nibbles). A configuration word gives the table contents and the mode of each nibble. A nibble can act as free logic, as a ripple-carry adder slice, or as part of a small synchronous memory. In memory mode the table storage itself becomes a 32-word by 4-bit RAM or ROM. Nine registers sit behind the lanes, one per lane plus one extra. Each register picks its input from one of four sources. Each register also has clock enable, local set/reset and a cell-wide global reset that the configuration can switch off.

A table or memory content is applied with a one-cycle load strobe that copies the configuration table bits into the storage. After that, the combinational lane outputs and the register outputs reflect the selected modes. The two nibbles can work as two 4-bit adders or be chained into one 8-bit adder. The extra register can capture the carry-out so that the carry is pipelined.

Top module: `twin_quad_cell`

## Requirements
- R1: In logic mode (nibble mode code 0), lane i drives `f_out[i]` with table bit `i*16 + lut_in[4*i+3:4*i]` of the loaded contents.
- R2: In arithmetic mode (code 1), each lane of a nibble adds operand A = `lut_in[4*i]` and operand B = the lane's table output, and the nibble's 4-bit sum appears on its `f_out` lanes. With `cfg_wide` = 0, nibble n takes `ci[n]` as carry-in and reports its carry-out on `co[n]`.
- R3: With `cfg_wide` = 1, nibble 1 takes its carry-in from nibble 0's carry-out and ignores `ci[1]`, so the cell forms one 8-bit adder whose carry-out is `co[1]`.
- R4: The extra register (index 8) with source code 0 captures `co[1]` when `cfg_wide` = 1 and `co[0]` otherwise, and shows it on `q_out[8]` one clock later.
- R5: Register i takes its input through `cfg_src[2i+1:2i]`: 0 = own lane output, 1 = `din[i]` XOR `cfg_din_inv[i]`, 2 = constant 1, 3 = constant 0.
- R6: When `lsr` of a register's group is high, the register takes `cfg_set[i]` on the next edge whatever its clock enable. Lanes 0-3 use group bit 0, lanes 4-7 use bit 1 and the extra register uses bit 2.
- R7: With its group's clock enable and local set/reset both low, a register holds its value.
- R8: With `cfg_gsr_en` = 1, `rst` forces every register to its `cfg_set` bit on the next edge. With `cfg_gsr_en` = 0, `rst` has no effect on the registers.
- R9: A write with `ram_we` stores `ram_wdata[k]` into entry `ram_waddr[3:0]` of lane `4*ram_waddr[4]+k`, but only if that nibble is in RAM mode (code 2). In ROM mode (code 3) the write is ignored.
- R10: `ram_rdata[k]` is the content of lane `4*ra[4]+k` at entry `ra[3:0]`. Here `ra` is `ram_raddr` when `cfg_dual` = 1 and `ram_waddr` otherwise. Reading an address during the cycle it is written returns the old contents.
- R11: A nibble in RAM or ROM mode drives its lane outputs with its own lanes' contents at entry `ra[3:0]`, and its `co` bit is 0.
- R12: `cfg_load` copies `cfg_lut` into the storage on the next edge. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous global set/reset, active high |
| cfg_load | input | 1 | Copy table contents into storage |
| cfg_lut | input | 128 | Table contents, lane i at bits 16i+15:16i |
| cfg_mode | input | 4 | Mode per nibble, 2 bits each |
| cfg_wide | input | 1 | Chain both nibbles into one 8-bit adder |
| cfg_dual | input | 1 | Separate read address for memory mode |
| cfg_src | input | 18 | Register input source, 2 bits per register |
| cfg_din_inv | input | 9 | Invert the direct input per register |
| cfg_set | input | 9 | Reset value per register |
| cfg_gsr_en | input | 1 | Let rst act on the registers |
| lut_in | input | 32 | Table inputs, 4 per lane |
| din | input | 9 | Direct register inputs |
| ci | input | 2 | Carry-in per nibble |
| ram_we | input | 1 | Memory write enable |
| ram_waddr | input | 5 | Memory write (and single-port read) address |
| ram_raddr | input | 5 | Memory read address in dual-port form |
| ram_wdata | input | 4 | Memory write data |
| ce | input | 3 | Clock enable per register group |
| lsr | input | 3 | Local set/reset per register group |
| f_out | output | 8 | Combinational lane outputs |
| q_out | output | 9 | Register outputs |
| co | output | 2 | Carry-out per nibble |
| ram_rdata | output | 4 | Memory read data |

## Verification
A memory write and a read of the same word can fall in the same cycle. In the dual-port form the read address comes from its own port, so this is a real collision. The bench copies the write address onto the read address in about a third of the memory cycles and also writes while a load is pending. The outputs sampled before the edge must show the previous word, and after the edge the new word or the loaded contents must appear. A local set/reset that arrives together with a clock enable is provoked by random group bits, and the register must take its reset value.

// File: rtl/tqc_pkg.sv
package tqc_pkg;
  typedef enum logic [1:0] {
    M_LOGIC = 2'd0,
    M_ARITH = 2'd1,
    M_RAM   = 2'd2,
    M_ROM   = 2'd3
  } nib_mode_e;

  typedef enum logic [1:0] {
    S_LANE   = 2'd0,
    S_DIRECT = 2'd1,
    S_HIGH   = 2'd2,
    S_LOW    = 2'd3
  } reg_src_e;
endpackage

// File: rtl/tqc_store.sv
module tqc_store #(
  parameter int LANES     = 8,
  parameter int NIB_LANES = 4,
  parameter int DEPTH     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [LANES*DEPTH-1:0] load_bits,
  input  logic                   wr_en,
  input  logic [$clog2(DEPTH)+$clog2(LANES/NIB_LANES)-1:0] waddr,
  input  logic [NIB_LANES-1:0]   wdata,
  input  logic [$clog2(DEPTH)+$clog2(LANES/NIB_LANES)-1:0] raddr,
  output logic [NIB_LANES-1:0]   rdata,
  output logic [LANES*DEPTH-1:0] bits
);
  localparam int AW  = $clog2(DEPTH);
  localparam int WAW = AW + $clog2(LANES / NIB_LANES);
  localparam int LW  = $clog2(LANES);

  logic [DEPTH-1:0] mem [LANES];

  // distributed-memory style: whole-table load or one 4-bit word per edge
  always_ff @(posedge clk) begin
    if (load) begin
      for (int l = 0; l < LANES; l++) mem[l] <= load_bits[l*DEPTH +: DEPTH];
    end else if (wr_en) begin
      for (int k = 0; k < NIB_LANES; k++)
        mem[LW'(int'(waddr[WAW-1:AW]) * NIB_LANES + k)][waddr[AW-1:0]] <= wdata[k];
    end
  end

  always_comb begin
    for (int k = 0; k < NIB_LANES; k++)
      rdata[k] = mem[LW'(int'(raddr[WAW-1:AW]) * NIB_LANES + k)][raddr[AW-1:0]];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_bits
    assign bits[l*DEPTH +: DEPTH] = mem[l];
  end

  // checker: a word written last edge is found at its address afterwards
  logic                 chk_armed;
  logic [WAW-1:0]       chk_addr;
  logic [NIB_LANES-1:0] chk_data;
  logic [NIB_LANES-1:0] chk_now;

  always_ff @(posedge clk) begin
    chk_armed <= wr_en && !load && !rst;
    chk_addr  <= waddr;
    chk_data  <= wdata;
  end

  always_comb begin
    for (int k = 0; k < NIB_LANES; k++)
      chk_now[k] = mem[LW'(int'(chk_addr[WAW-1:AW]) * NIB_LANES + k)][chk_addr[AW-1:0]];
  end

  p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
    chk_armed |-> chk_now == chk_data);
endmodule

// File: rtl/tqc_nibble.sv
module tqc_nibble
  import tqc_pkg::*;
#(
  parameter int NIB_LANES = 4,
  parameter int DEPTH     = 16,
  parameter int AW        = $clog2(DEPTH)
) (
  input  nib_mode_e                    mode,
  input  logic [NIB_LANES*DEPTH-1:0]   lut_bits,
  input  logic [NIB_LANES*AW-1:0]      sel,
  input  logic [AW-1:0]                ram_idx,
  input  logic                         cin,
  output logic [NIB_LANES-1:0]         f,
  output logic                         cout
);
  logic                 use_mem;
  logic [NIB_LANES:0]   c;
  logic [NIB_LANES-1:0] t, opa, sum;

  assign use_mem = (mode == M_RAM) || (mode == M_ROM);
  assign c[0]    = cin;

  for (genvar k = 0; k < NIB_LANES; k++) begin : g_lane
    logic [AW-1:0] idx;
    assign idx      = use_mem ? ram_idx : sel[k*AW +: AW];
    assign t[k]     = lut_bits[k*DEPTH + int'(idx)];
    assign opa[k]   = sel[k*AW];
    assign sum[k]   = opa[k] ^ t[k] ^ c[k];
    assign c[k+1]   = (opa[k] & t[k]) | (c[k] & (opa[k] ^ t[k]));
  end

  assign f    = (mode == M_ARITH) ? sum : t;
  assign cout = (mode == M_ARITH) ? c[NIB_LANES] : 1'b0;
endmodule

// File: rtl/tqc_ff.sv
module tqc_ff
  import tqc_pkg::*;
#(
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic     clk,
  input  logic     gsr,
  input  logic     lsr,
  input  logic     ce,
  input  reg_src_e src,
  input  logic     own_d,
  input  logic     din,
  input  logic     din_inv,
  input  logic     set_val,
  output logic     q
);
  logic d;

  always_comb begin
    case (src)
      S_LANE:   d = own_d;
      S_DIRECT: d = din ^ din_inv;
      S_HIGH:   d = 1'b1;
      default:  d = 1'b0;
    endcase
  end

  if (NEG_EDGE) begin : g_neg
    always_ff @(negedge clk) begin
      if (gsr)      q <= set_val;
      else if (lsr) q <= set_val;
      else if (ce)  q <= d;
    end
  end else begin : g_pos
    always_ff @(posedge clk) begin
      if (gsr)      q <= set_val;
      else if (lsr) q <= set_val;
      else if (ce)  q <= d;
    end

    p_lsr_wins_r6: assert property (@(posedge clk) disable iff (gsr)
      lsr |=> q == $past(set_val));

    p_hold_r7: assert property (@(posedge clk) disable iff (gsr)
      (!lsr && !ce) |=> $stable(q));
  end
endmodule

// File: rtl/twin_quad_cell.sv
module twin_quad_cell
  import tqc_pkg::*;
#(
  parameter int LUT_INPUTS = 4,
  parameter int NIB_LANES  = 4,
  parameter int NIBBLES    = 2,
  parameter logic [NIBBLES*NIB_LANES:0] CLK_NEG = '0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cfg_load,
  input  logic [NIBBLES*NIB_LANES*(2**LUT_INPUTS)-1:0] cfg_lut,
  input  logic [2*NIBBLES-1:0]                 cfg_mode,
  input  logic                                 cfg_wide,
  input  logic                                 cfg_dual,
  input  logic [2*(NIBBLES*NIB_LANES+1)-1:0]   cfg_src,
  input  logic [NIBBLES*NIB_LANES:0]           cfg_din_inv,
  input  logic [NIBBLES*NIB_LANES:0]           cfg_set,
  input  logic                                 cfg_gsr_en,
  input  logic [NIBBLES*NIB_LANES*LUT_INPUTS-1:0] lut_in,
  input  logic [NIBBLES*NIB_LANES:0]           din,
  input  logic [NIBBLES-1:0]                   ci,
  input  logic                                 ram_we,
  input  logic [LUT_INPUTS+$clog2(NIBBLES)-1:0] ram_waddr,
  input  logic [LUT_INPUTS+$clog2(NIBBLES)-1:0] ram_raddr,
  input  logic [NIB_LANES-1:0]                 ram_wdata,
  input  logic [NIBBLES:0]                     ce,
  input  logic [NIBBLES:0]                     lsr,
  output logic [NIBBLES*NIB_LANES-1:0]         f_out,
  output logic [NIBBLES*NIB_LANES:0]           q_out,
  output logic [NIBBLES-1:0]                   co,
  output logic [NIB_LANES-1:0]                 ram_rdata
);
  localparam int DEPTH = 2 ** LUT_INPUTS;
  localparam int AW    = LUT_INPUTS;
  localparam int LANES = NIBBLES * NIB_LANES;
  localparam int REGS  = LANES + 1;
  localparam int WAW   = AW + $clog2(NIBBLES);
  localparam int NBITS = NIB_LANES * DEPTH;

  nib_mode_e              mode_n [NIBBLES];
  nib_mode_e              wr_mode;
  logic [LANES*DEPTH-1:0] lut_bits;
  logic [WAW-1:0]         ra_eff;
  logic                   wr_ok;
  logic                   gsr_act;
  logic                   x_carry;

  for (genvar n = 0; n < NIBBLES; n++) begin : g_mode
    assign mode_n[n] = nib_mode_e'(cfg_mode[2*n +: 2]);
  end

  assign ra_eff  = cfg_dual ? ram_raddr : ram_waddr;
  assign wr_mode = mode_n[ram_waddr[WAW-1:AW]];
  assign wr_ok   = ram_we && (wr_mode == M_RAM);
  assign gsr_act = rst && cfg_gsr_en;

  tqc_store #(
    .LANES(LANES), .NIB_LANES(NIB_LANES), .DEPTH(DEPTH)
  ) u_store (
    .clk(clk), .rst(rst), .load(cfg_load), .load_bits(cfg_lut),
    .wr_en(wr_ok), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ra_eff), .rdata(ram_rdata), .bits(lut_bits)
  );

  for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
    logic cin_n;
    if (n == 0) begin : g_first
      assign cin_n = ci[0];
    end else begin : g_next
      assign cin_n = cfg_wide ? co[n-1] : ci[n];
    end

    tqc_nibble #(
      .NIB_LANES(NIB_LANES), .DEPTH(DEPTH)
    ) u_nib (
      .mode(mode_n[n]),
      .lut_bits(lut_bits[n*NBITS +: NBITS]),
      .sel(lut_in[n*NIB_LANES*AW +: NIB_LANES*AW]),
      .ram_idx(ra_eff[AW-1:0]),
      .cin(cin_n),
      .f(f_out[n*NIB_LANES +: NIB_LANES]),
      .cout(co[n])
    );

    p_ram_no_carry_r11: assert property (@(posedge clk) disable iff (rst)
      (mode_n[n] == M_RAM || mode_n[n] == M_ROM) |-> !co[n]);
  end

  assign x_carry = cfg_wide ? co[NIBBLES-1] : co[0];

  for (genvar i = 0; i < REGS; i++) begin : g_reg
    localparam int GRP = (i < LANES) ? i / NIB_LANES : NIBBLES;
    logic own_d;
    if (i < LANES) begin : g_lane_src
      assign own_d = f_out[i];
    end else begin : g_carry_src
      assign own_d = x_carry;
    end

    tqc_ff #(
      .NEG_EDGE(CLK_NEG[i])
    ) u_ff (
      .clk(clk), .gsr(gsr_act), .lsr(lsr[GRP]), .ce(ce[GRP]),
      .src(reg_src_e'(cfg_src[2*i +: 2])),
      .own_d(own_d), .din(din[i]), .din_inv(cfg_din_inv[i]),
      .set_val(cfg_set[i]), .q(q_out[i])
    );
  end

  p_rom_ignores_r9: assert property (@(posedge clk) disable iff (rst)
    (ram_we && wr_mode == M_ROM && !cfg_load) |=> $stable(lut_bits));
endmodule

// File: tb/twin_quad_cell_test.sv
module twin_quad_cell_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, cfg_load, cfg_wide, cfg_dual, cfg_gsr_en, ram_we;
  logic [127:0] cfg_lut;
  logic [3:0]   cfg_mode;
  logic [17:0]  cfg_src;
  logic [8:0]   cfg_din_inv, cfg_set, din, q_out;
  logic [31:0]  lut_in;
  logic [1:0]   ci, co;
  logic [4:0]   ram_waddr, ram_raddr;
  logic [3:0]   ram_wdata, ram_rdata;
  logic [2:0]   ce, lsr;
  logic [7:0]   f_out;

  int n_run  = 0;
  int n_fail = 0;
  bit checking = 1'b0;
  bit [127:0] m_mem;
  bit [8:0]   m_q;

  twin_quad_cell uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_lut(cfg_lut),
    .cfg_mode(cfg_mode), .cfg_wide(cfg_wide), .cfg_dual(cfg_dual),
    .cfg_src(cfg_src), .cfg_din_inv(cfg_din_inv), .cfg_set(cfg_set),
    .cfg_gsr_en(cfg_gsr_en), .lut_in(lut_in), .din(din), .ci(ci),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_raddr(ram_raddr),
    .ram_wdata(ram_wdata), .ce(ce), .lsr(lsr), .f_out(f_out),
    .q_out(q_out), .co(co), .ram_rdata(ram_rdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural expectation of the combinational outputs
  task automatic model_comb(output bit [7:0] fe, output bit [1:0] coe, output bit [3:0] rde);
    bit [4:0] ra;
    bit [7:0] t, a;
    int s;
    ra = cfg_dual ? ram_raddr : ram_waddr;
    for (int i = 0; i < 8; i++) begin
      int md  = int'(cfg_mode[2*(i/4) +: 2]);
      int idx = (md >= 2) ? int'(ra[3:0]) : int'(lut_in[4*i +: 4]);
      t[i] = m_mem[16*i + idx];
      a[i] = lut_in[4*i];
    end
    fe  = t;
    coe = 2'b00;
    for (int n = 0; n < 2; n++) begin
      int md = int'(cfg_mode[2*n +: 2]);
      bit cn = (n == 1 && cfg_wide) ? coe[0] : ci[n];
      if (md == 1) begin
        s = int'(a[4*n +: 4]) + int'(t[4*n +: 4]) + int'(cn);
        fe[4*n +: 4] = s[3:0];
        coe[n] = s[4];
      end
    end
    for (int k = 0; k < 4; k++)
      rde[k] = m_mem[16*(4*int'(ra[4]) + k) + int'(ra[3:0])];
  endtask

  task automatic step(string req);
    bit [7:0] fe;
    bit [1:0] coe;
    bit [3:0] rde;
    bit [8:0] nq;
    bit d;
    int g;
    #1;
    model_comb(fe, coe, rde);
    if (checking) begin
      chk(req, "f_out", 32'(f_out), 32'(fe));
      chk(req, "co", 32'(co), 32'(coe));
      chk(req, "ram_rdata", 32'(ram_rdata), 32'(rde));
      chk(req, "q_out", 32'(q_out), 32'(m_q));
    end
    for (int i = 0; i < 9; i++) begin
      g = (i < 8) ? i / 4 : 2;
      case (cfg_src[2*i +: 2])
        2'd0:    d = (i < 8) ? fe[i] : (cfg_wide ? coe[1] : coe[0]);
        2'd1:    d = din[i] ^ cfg_din_inv[i];
        2'd2:    d = 1'b1;
        default: d = 1'b0;
      endcase
      if (rst && cfg_gsr_en) nq[i] = cfg_set[i];
      else if (lsr[g])       nq[i] = cfg_set[i];
      else if (ce[g])        nq[i] = d;
      else                   nq[i] = m_q[i];
    end
    @(posedge clk);
    m_q = nq;
    if (cfg_load) m_mem = cfg_lut;
    else if (ram_we && cfg_mode[2*ram_waddr[4] +: 2] == 2'd2)
      for (int k = 0; k < 4; k++)
        m_mem[16*(4*int'(ram_waddr[4]) + k) + int'(ram_waddr[3:0])] = ram_wdata[k];
    @(negedge clk);
  endtask

  task automatic run(int cycles, string req);
    for (int c = 0; c < cycles; c++) begin
      lut_in    = $urandom;
      din       = 9'($urandom);
      ci        = 2'($urandom);
      for (int b = 0; b < 3; b++) begin
        ce[b]  = ($urandom % 4) != 0;
        lsr[b] = ($urandom % 6) == 0;
      end
      ram_we    = 1'($urandom);
      ram_waddr = 5'($urandom);
      ram_raddr = (($urandom % 3) == 0) ? ram_waddr : 5'($urandom);
      ram_wdata = 4'($urandom);
      step(req);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    rst = 1'b1; cfg_gsr_en = 1'b1; cfg_load = 1'b1; cfg_lut = rnd128();
    cfg_mode = 4'b0000; cfg_wide = 1'b0; cfg_dual = 1'b1;
    cfg_src = 18'($urandom); cfg_din_inv = 9'($urandom); cfg_set = 9'($urandom);
    lut_in = '0; din = '0; ci = '0; ram_we = 1'b0; ram_waddr = '0;
    ram_raddr = '0; ram_wdata = '0; ce = '0; lsr = '0;
    step("init");
    checking = 1'b1;
    cfg_load = 1'b0;
    // R8: reset state equals the per-register reset values
    step("R8");
    rst = 1'b0;

    // R1 R5 R6 R7: logic mode, all register sources
    run(50, "R1 R5 R6 R7");

    // R2 R4: two independent 4-bit adders, carry pipelined in register 8
    cfg_mode = 4'b0101; cfg_wide = 1'b0; cfg_src = 18'd0;
    run(40, "R2 R4");

    // R3 R4: one 8-bit adder
    cfg_wide = 1'b1;
    run(40, "R3 R4");

    // R11 R2: nibble 0 memory, nibble 1 adder
    cfg_mode = 4'b0110; cfg_wide = 1'b0; cfg_src = 18'($urandom);
    run(30, "R11 R2");

    // R9 R10 R11: dual-port memory, same-address collisions included
    cfg_mode = 4'b1010; cfg_dual = 1'b1;
    run(60, "R9 R10 R11");

    // R10: single-port form
    cfg_dual = 1'b0;
    run(30, "R10");

    // R9: nibble 1 as ROM ignores writes, nibble 0 RAM still written
    cfg_mode = 4'b1110; cfg_dual = 1'b1;
    run(40, "R9");

    // R12: load collides with a write
    cfg_mode = 4'b1010;
    cfg_load = 1'b1; cfg_lut = rnd128();
    ram_we = 1'b1; ram_waddr = 5'd7; ram_wdata = 4'hF; ram_raddr = 5'd7;
    step("R12");
    cfg_load = 1'b0;
    run(15, "R12");

    // R8: rst ignored with global reset disabled
    cfg_gsr_en = 1'b0; rst = 1'b1;
    cfg_mode = 4'b0000; cfg_src = 18'($urandom);
    run(15, "R8");
    rst = 1'b0; cfg_gsr_en = 1'b1;
    run(10, "R1 R5");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule